// File: doc/BRIEF.md
# DTMF Transceiver Host Register Port

This block is the host-side register port of a DTMF transceiver. An external processor reaches five internal registers through a 4-bit data path, an active-low chip select, active-low read and write strobes and a single register-select line. The strobes are asynchronous to the core clock. They are brought into the clock domain through a flip-flop synchronizer, and an access takes effect when its strobe returns high. The host bus is modelled as separate input and output halves plus an output-enable, so that a pad ring can form the tristate pin.

A write with select low loads the transmit code register, which feeds the tone generator. A write with select high loads one of two control registers. When the redirect bit of control A is set, the next such write goes to control B and then clears the redirect bit.

A read with select low returns the receive code, which the steering logic delivers with a one-cycle event pulse. A read with select high returns the status word. Its delayed-steering flag is set by each receive event and cleared when a status read completes. When the interrupt-enable bit of control A is set and the flag is up, the open-drain interrupt output is pulled low.

Top module: `dtmf_host_port`

## Requirements
- R1: After synchronous reset, `tx_code`, `ctrl_a` and `ctrl_b` are 0, the receive code and the status flag are 0, `irq_n` is 1 and `dout_oe` is 0.
- R2: `dout_oe` is 1 only while both `cs_n` and `rd_n` are low. Whenever `dout_oe` is 0, `dout` is 0.
- R3: During a read, `dout` shows the receive code when `rsel`=0. When `rsel`=1 it shows the status word: the delayed-steering flag is at bit 2 and bits 3, 1 and 0 read 0.
- R4: A write with `rsel`=0 loads `din` into `tx_code` no later than three clock cycles after `wr_n` rises.
- R5: A write with `rsel`=1 while `ctrl_a` bit 3 (redirect) is 0 loads all four bits of `din` into `ctrl_a`.
- R6: A write with `rsel`=1 while `ctrl_a` bit 3 is 1 loads `din` into `ctrl_b` and clears `ctrl_a` bit 3 only. The following such write goes to `ctrl_a` again.
- R7: A one-cycle `rx_strobe` latches `rx_code` as the receive code and sets the status flag on the next clock edge.
- R8: `irq_n` is 0 exactly while the status flag is 1 and `ctrl_a` bit 2 (interrupt enable) is 1. Otherwise it is 1 (released).
- R9: Completing a status read (`rsel`=1) clears the flag and so releases `irq_n`. A receive-code read (`rsel`=0) leaves the flag unchanged.
- R10: Strobes given while `cs_n` is high change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rsel | input | 1 | Register select |
| din | input | 4 | Host write data |
| dout | output | 4 | Host read data |
| dout_oe | output | 1 | Output enable for the host data pins |
| irq_n | output | 1 | Interrupt request, 0 = pull low, 1 = released |
| rx_strobe | input | 1 | One-cycle delayed-steering event from the steering block |
| rx_code | input | 4 | Decoded tone code that goes with `rx_strobe` |
| tx_code | output | 4 | Transmit code register to the tone generator |
| ctrl_a | output | 4 | Control A: bit 3 redirect, bit 2 interrupt enable, bits 1:0 mode |
| ctrl_b | output | 4 | Control B |

## Verification
The register assertions assume that the host keeps `cs_n`, `rsel` and `din` steady from before its strobe falls until a few cycles after the strobe rises. Under that assumption, the synchronized copies line up with the strobe edge. They also assume that `rx_strobe` lasts one cycle. The bench drives every access on falling clock edges. It holds select and data for several cycles on each side of the strobe and keeps receive events well apart from host reads, so the order of a status-read clear and a receive event never becomes a race.

// File: rtl/dtmf_host_pkg.sv
package dtmf_host_pkg;

    localparam int DW       = 4;
    localparam int FLAG_BIT = 2;

    // control A layout: redirect steers the next control write to B
    typedef struct packed {
        logic       redirect;
        logic       irq_en;
        logic [1:0] mode;
    } ctrl_a_t;

    // one decoded host access, valid for one clock
    typedef struct packed {
        logic          wr;
        logic          rd;
        logic          rsel;
        logic [DW-1:0] data;
    } host_acc_t;

    function automatic logic [DW-1:0] status_word(input logic flag);
        logic [DW-1:0] w;
        w           = '0;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/dtmf_strobe_sync.sv
module dtmf_strobe_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '1;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '1;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dtmf_access_decode.sv
module dtmf_access_decode
    import dtmf_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          rsel_s,
    input  logic [DW-1:0] din_s,
    output host_acc_t     acc
);
    logic          cs_n_d, rd_n_d, wr_n_d, rsel_d;
    logic [DW-1:0] din_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_d <= 1'b1;
            rd_n_d <= 1'b1;
            wr_n_d <= 1'b1;
            rsel_d <= 1'b0;
            din_d  <= '0;
        end else begin
            cs_n_d <= cs_n_s;
            rd_n_d <= rd_n_s;
            wr_n_d <= wr_n_s;
            rsel_d <= rsel_s;
            din_d  <= din_s;
        end
    end

    // act on the strobe's return to high; select sampled while it was low
    always_comb begin
        acc.wr   = wr_n_s & ~wr_n_d & ~cs_n_d;
        acc.rd   = rd_n_s & ~rd_n_d & ~cs_n_d;
        acc.rsel = rsel_d;
        acc.data = din_d;
    end
endmodule

// File: rtl/dtmf_reg_bank.sv
module dtmf_reg_bank
    import dtmf_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  host_acc_t     acc,
    input  logic          rx_strobe,
    input  logic [DW-1:0] rx_code,
    output logic [DW-1:0] tx_q,
    output ctrl_a_t       ctrl_a_q,
    output logic [DW-1:0] ctrl_b_q,
    output logic [DW-1:0] rx_q,
    output logic          flag_q,
    output logic          irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
        end else if (acc.wr) begin
            if (!acc.rsel) begin
                tx_q <= acc.data;
            end else if (ctrl_a_q.redirect) begin
                ctrl_b_q          <= acc.data;
                ctrl_a_q.redirect <= 1'b0;
            end else begin
                ctrl_a_q <= ctrl_a_t'(acc.data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            flag_q <= 1'b0;
        end else if (rx_strobe) begin
            rx_q   <= rx_code;
            flag_q <= 1'b1;
        end else if (acc.rd && acc.rsel) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_n = ~(flag_q & ctrl_a_q.irq_en);

    // R7
    rx_latch_chk: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> (flag_q && rx_q == $past(rx_code)));

    // R4
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && !acc.rsel) |=> tx_q == $past(acc.data));

    // R6
    redirect_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.rsel && ctrl_a_q.redirect)
            |=> (!ctrl_a_q.redirect && ctrl_b_q == $past(acc.data)));

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.rsel && !rx_strobe) |=> !flag_q);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc.wr && !acc.rsel) |=> $stable(tx_q));
endmodule

// File: rtl/dtmf_host_port.sv
module dtmf_host_port
    import dtmf_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          rsel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          irq_n,
    input  logic          rx_strobe,
    input  logic [DW-1:0] rx_code,
    output logic [DW-1:0] tx_code,
    output logic [DW-1:0] ctrl_a,
    output logic [DW-1:0] ctrl_b
);
    localparam int SW = DW + 4;

    logic [SW-1:0] raw_vec, sync_vec;
    host_acc_t     acc;
    ctrl_a_t       ca_q;
    logic [DW-1:0] rx_q;
    logic          flag_q;
    logic [DW-1:0] rd_word;

    assign raw_vec = {cs_n, rd_n, wr_n, rsel, din};

    dtmf_strobe_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_vec),
        .q   (sync_vec)
    );

    dtmf_access_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (sync_vec[SW-1]),
        .rd_n_s (sync_vec[SW-2]),
        .wr_n_s (sync_vec[SW-3]),
        .rsel_s (sync_vec[SW-4]),
        .din_s  (sync_vec[DW-1:0]),
        .acc    (acc)
    );

    dtmf_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rx_strobe (rx_strobe),
        .rx_code   (rx_code),
        .tx_q      (tx_code),
        .ctrl_a_q  (ca_q),
        .ctrl_b_q  (ctrl_b),
        .rx_q      (rx_q),
        .flag_q    (flag_q),
        .irq_n     (irq_n)
    );

    assign ctrl_a  = ca_q;
    assign rd_word = rsel ? status_word(flag_q) : rx_q;
    assign dout_oe = ~cs_n & ~rd_n;
    assign dout    = dout_oe ? rd_word : '0;

    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (flag_q && ctrl_a[2]));
endmodule

// File: tb/dtmf_host_port_bench.sv
`timescale 1ns/1ps
module dtmf_host_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rsel = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_oe, irq_n;
    logic       rx_strobe = 1'b0;
    logic [3:0] rx_code = '0;
    logic [3:0] tx_code, ctrl_a, ctrl_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int         sel;
        logic [3:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dtmf_host_port u_dtmf_host_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rsel(rsel), .din(din), .dout(dout), .dout_oe(dout_oe),
        .irq_n(irq_n), .rx_strobe(rx_strobe), .rx_code(rx_code),
        .tx_code(tx_code), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    // sel codes: 0 dout, 1 dout_oe, 2 irq_n, 3 tx_code, 4 ctrl_a, 5 ctrl_b
    function automatic logic [3:0] observe(input int sel);
        case (sel)
            0:       return dout;
            1:       return {3'b0, dout_oe};
            2:       return {3'b0, irq_n};
            3:       return tx_code;
            4:       return ctrl_a;
            default: return ctrl_b;
        endcase
    endfunction

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [3:0] got;
                it  = sb_q.pop_front();
                got = observe(it.sel);
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int sel, input logic [3:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic host_write(input logic sel, input logic [3:0] val, input logic csn);
        @(negedge clk); cs_n = csn; rsel = sel; din = val;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_read(input logic sel, input logic [3:0] exp, input string req);
        @(negedge clk); cs_n = 1'b0; rsel = sel;
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        expect_val(1, 4'h1, "R2");
        expect_val(0, exp, req);
        @(negedge clk); rd_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        expect_val(1, 4'h0, "R2");
        expect_val(0, 4'h0, "R2");
    endtask

    task automatic rx_event(input logic [3:0] code);
        @(negedge clk); rx_code = code; rx_strobe = 1'b1;
        @(negedge clk); rx_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_val(3, 4'h0, "R1");
        expect_val(4, 4'h0, "R1");
        expect_val(5, 4'h0, "R1");
        expect_val(2, 4'h1, "R1");
        expect_val(1, 4'h0, "R1");

        // R2 no drive unless both low
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); expect_val(1, 4'h0, "R2");
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); expect_val(1, 4'h0, "R2");
        expect_val(0, 4'h0, "R2");
        @(negedge clk); rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 transmit writes
        host_write(1'b0, 4'h9, 1'b0); expect_val(3, 4'h9, "R4");
        host_write(1'b0, 4'h6, 1'b0); expect_val(3, 4'h6, "R4");

        // R5 control A
        host_write(1'b1, 4'h4, 1'b0);
        expect_val(4, 4'h4, "R5"); expect_val(5, 4'h0, "R5");
        host_write(1'b1, 4'hC, 1'b0); expect_val(4, 4'hC, "R5");

        // R6 redirect to B, then back to A
        host_write(1'b1, 4'h7, 1'b0);
        expect_val(5, 4'h7, "R6"); expect_val(4, 4'h4, "R6");
        host_write(1'b1, 4'h5, 1'b0);
        expect_val(4, 4'h5, "R6"); expect_val(5, 4'h7, "R6");

        // R10 strobe without chip select
        host_write(1'b0, 4'hF, 1'b1); expect_val(3, 4'h6, "R10");
        host_write(1'b1, 4'hA, 1'b1);
        expect_val(4, 4'h5, "R10"); expect_val(5, 4'h7, "R10");

        // R7, R8 receive event with interrupt enabled
        expect_val(2, 4'h1, "R8");
        rx_event(4'hB);
        expect_val(2, 4'h0, "R8");
        host_read(1'b0, 4'hB, "R3");
        expect_val(2, 4'h0, "R9");
        host_read(1'b1, 4'h4, "R3");
        @(negedge clk); expect_val(2, 4'h1, "R9");
        host_read(1'b1, 4'h0, "R9");

        // R7 new code; receive read leaves the flag
        rx_event(4'h3);
        host_read(1'b0, 4'h3, "R7");
        host_read(1'b1, 4'h4, "R9");
        host_read(1'b1, 4'h0, "R9");

        // R8 interrupt disabled: flag up, line released
        host_write(1'b1, 4'h0, 1'b0);
        rx_event(4'h0);
        expect_val(2, 4'h1, "R8");
        host_read(1'b1, 4'h4, "R8");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule